// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block counts hardware events for software profiling. Two 32-bit counters each pick one event strobe from a bank of event inputs, using a 12-bit select code held in a shared control word. A counter adds one on every cycle in which its chosen strobe is high and the control word permits counting in the privilege context reported on `priv_ctx`. The counting permissions for user, supervisor and hypervisor context are common to both counters. To halt one counter while the other keeps running, software programs the reserved select code 0x220 into that counter's field.

Software reaches the unit through one register port with three addresses: the control word, a 64-bit packed view of both counters, and an overflow status word. When a counter rolls over from all ones to zero, a sticky flag is latched for that counter. This happens even for a counter that software treats as idle, so that the handler can check the flag and throw it away. The interrupt output combines each flag with its own enable bit. Any write to the control word clears both flags.

Top module: `pmu_dual_counter`

## Requirements
- R1: After reset, both counters read 0, the control word reads 0, the status word reads 0 and `irq` is low.
- R2: Address 1 reads as {upper counter, lower counter}, with the upper counter in bits 63:32 and the lower counter in bits 31:0. A write to address 1 loads the lower counter from bits 31:0 when `reg_half[0]` is set and the upper counter from bits 63:32 when `reg_half[1]` is set. A half whose bit is clear keeps its value.
- R3: Address 0 holds the control word and reads back bits 30:0 as written. Bit 1 permits counting in user context, bit 2 in supervisor context and bit 3 in hypervisor context. Bit 4 is the lower counter's interrupt enable and bit 5 is the upper counter's. Bits 17:6 select the lower counter's event and bits 30:19 select the upper counter's event.
- R4: A counter adds exactly one in each cycle in which `evt_strobe[code]` is high for its select code and the permission bit for `priv_ctx` is set. `priv_ctx` encodes 0 = user, 1 = supervisor and 2 = hypervisor. A value of 3 never counts.
- R5: When all three context bits are clear, neither counter changes, whatever the strobes do.
- R6: Select code 0x220, and any code at or above the number of event inputs, never advances its counter. The other counter keeps counting.
- R7: A counter load through address 1 takes priority over an increment of that counter in the same cycle. The other counter still increments.
- R8: Status address 2 shows sticky overflow flags: bit 0 for the lower counter and bit 1 for the upper counter. A flag sets only when an increment takes a counter from 0xFFFFFFFF to 0. Loading values through the port never sets a flag.
- R9: `irq` is high exactly when some flag is set together with its enable bit. A flag still sets when its enable bit is clear, and `irq` then stays low.
- R10: Any control-word write clears both flags and drops `irq`, even when the written value is unchanged. A rollover in the same cycle as that write sets its flag anyway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 counters, 2 status |
| reg_wdata | input | 64 | Write data |
| reg_half | input | 2 | Counter half-write enables: bit 0 lower, bit 1 upper |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| evt_strobe | input | NUM_EVENTS | Event strobes, indexed by select code |
| priv_ctx | input | 2 | Current privilege context |
| irq | output | 1 | Overflow interrupt |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a counter load and an event increment of that counter. The second pair is a control-word write and a counter rollover. The bench provokes both by raising the strobe on the same falling edge on which it drives the write. It judges the first by reading back the loaded value, and checks that the neighbouring counter still advanced. It judges the second by requiring the flag and `irq` to be set after the edge, although the control write alone would have cleared them.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

   localparam int CNT_NUM    = 2;
   localparam int LO_IDX     = 0;
   localparam int HI_IDX     = 1;

   // control word bit positions
   localparam int US_BIT     = 1;
   localparam int SV_BIT     = 2;
   localparam int HV_BIT     = 3;
   localparam int IE_LSB     = 4;
   localparam int LO_SEL_LSB = 6;
   localparam int HI_SEL_LSB = 19;

   typedef enum logic [1:0] {
      CTX_USER  = 2'd0,
      CTX_SUPER = 2'd1,
      CTX_HYPER = 2'd2,
      CTX_NONE  = 2'd3
   } priv_ctx_e;

   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_CNT  = 2'd1,
      RA_STAT = 2'd2,
      RA_RSVD = 2'd3
   } reg_addr_e;

endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
   import pmu_pkg::*;
#(
   parameter int SEL_W  = 12,
   parameter int CTRL_W = HI_SEL_LSB + SEL_W
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [CTRL_W-1:0]                wdata,
   input  logic [1:0]                       priv_ctx,
   output logic [CTRL_W-1:0]                ctrl_q,
   output logic [CNT_NUM-1:0][SEL_W-1:0]    sel_vec,
   output logic [CNT_NUM-1:0]               ie,
   output logic                             ctx_ok
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (wr_en) ctrl_q <= wdata;
   end

   for (genvar i = 0; i < CNT_NUM; i++) begin : g_field
      localparam int LSB = (i == HI_IDX) ? HI_SEL_LSB : LO_SEL_LSB;
      assign sel_vec[i] = ctrl_q[LSB +: SEL_W];
      assign ie[i]      = ctrl_q[IE_LSB + i];
   end

   // one permission set governs both counters
   always_comb begin
      case (priv_ctx_e'(priv_ctx))
         CTX_USER:  ctx_ok = ctrl_q[US_BIT];
         CTX_SUPER: ctx_ok = ctrl_q[SV_BIT];
         CTX_HYPER: ctx_ok = ctrl_q[HV_BIT];
         default:   ctx_ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/pmu_event_counter.sv
module pmu_event_counter #(
   parameter int CNT_W      = 32,
   parameter int SEL_W      = 12,
   parameter int NUM_EVENTS = 16,
   parameter int PARK_CODE  = 'h220
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [CNT_W-1:0]      wr_val,
   input  logic [SEL_W-1:0]      sel,
   input  logic                  ctx_ok,
   input  logic [NUM_EVENTS-1:0] evt_strobe,
   output logic [CNT_W-1:0]      count,
   output logic                  wrap
);

   localparam int IDX_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;
   localparam logic [SEL_W-1:0] PARK = SEL_W'(PARK_CODE);

   logic in_range;
   logic hit;
   logic inc;

   // pick the range test that fits the select width
   if (NUM_EVENTS >= (1 << SEL_W)) begin : g_full_range
      assign in_range = 1'b1;
   end else begin : g_part_range
      assign in_range = (sel < SEL_W'(NUM_EVENTS));
   end

   assign hit  = (sel != PARK) && in_range && evt_strobe[sel[IDX_W-1:0]];
   assign inc  = ctx_ok && hit && !wr_en;
   assign wrap = inc && (&count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (wr_en)  count <= wr_val;
      else if (inc)    count <= count + CNT_W'(1);
   end

endmodule

// File: rtl/pmu_ovf_flags.sv
module pmu_ovf_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] wrap,
   input  logic         clr,
   input  logic [N-1:0] ie,
   output logic [N-1:0] flags,
   output logic         irq
);

   logic [N-1:0] flags_d;

   // a rollover in the clearing cycle survives the clear
   assign flags_d = clr ? wrap : (flags | wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= flags_d;
   end

   assign irq = |(flags & ie);

endmodule

// File: rtl/pmu_dual_counter.sv
module pmu_dual_counter
   import pmu_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int SEL_W      = 12,
   parameter int NUM_EVENTS = 16,
   parameter int PARK_CODE  = 'h220
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [1:0]            reg_addr,
   input  logic [2*CNT_W-1:0]    reg_wdata,
   input  logic [1:0]            reg_half,
   output logic [2*CNT_W-1:0]    reg_rdata,
   input  logic [NUM_EVENTS-1:0] evt_strobe,
   input  logic [1:0]            priv_ctx,
   output logic                  irq
);

   localparam int RD_W   = 2 * CNT_W;
   localparam int CTRL_W = HI_SEL_LSB + SEL_W;

   if (LO_SEL_LSB + SEL_W > HI_SEL_LSB) begin : g_bad_fields
      $error("select fields overlap for SEL_W=%0d", SEL_W);
   end
   if (CTRL_W > RD_W) begin : g_bad_ctrl
      $error("control word wider than read port");
   end
   if (NUM_EVENTS < 1 || NUM_EVENTS > (1 << SEL_W)) begin : g_bad_events
      $error("NUM_EVENTS out of range");
   end
   if (PARK_CODE >= (1 << SEL_W)) begin : g_bad_park
      $error("PARK_CODE does not fit in SEL_W");
   end

   logic                          ctrl_wr;
   logic                          cnt_acc;
   logic                          ctx_ok;
   logic [CTRL_W-1:0]             ctrl_q;
   logic [CNT_NUM-1:0][SEL_W-1:0] sel_vec;
   logic [CNT_NUM-1:0]            ie;
   logic [CNT_NUM-1:0]            cnt_wr;
   logic [CNT_NUM-1:0]            wrap;
   logic [CNT_NUM-1:0]            flags;
   logic [CNT_NUM-1:0][CNT_W-1:0] cnt;

   assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
   assign cnt_acc = reg_wr && (reg_addr == RA_CNT);

   pmu_ctrl_reg #(.SEL_W(SEL_W), .CTRL_W(CTRL_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ctrl_wr),
      .wdata    (reg_wdata[CTRL_W-1:0]),
      .priv_ctx (priv_ctx),
      .ctrl_q   (ctrl_q),
      .sel_vec  (sel_vec),
      .ie       (ie),
      .ctx_ok   (ctx_ok)
   );

   for (genvar i = 0; i < CNT_NUM; i++) begin : g_cnt
      assign cnt_wr[i] = cnt_acc && reg_half[i];
      pmu_event_counter #(
         .CNT_W      (CNT_W),
         .SEL_W      (SEL_W),
         .NUM_EVENTS (NUM_EVENTS),
         .PARK_CODE  (PARK_CODE)
      ) u_cnt (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (cnt_wr[i]),
         .wr_val     (reg_wdata[i*CNT_W +: CNT_W]),
         .sel        (sel_vec[i]),
         .ctx_ok     (ctx_ok),
         .evt_strobe (evt_strobe),
         .count      (cnt[i]),
         .wrap       (wrap[i])
      );
   end

   pmu_ovf_flags #(.N(CNT_NUM)) u_ovf (
      .clk   (clk),
      .rst_n (rst_n),
      .wrap  (wrap),
      .clr   (ctrl_wr),
      .ie    (ie),
      .flags (flags),
      .irq   (irq)
   );

   always_comb begin
      case (reg_addr_e'(reg_addr))
         RA_CTRL: reg_rdata = RD_W'(ctrl_q);
         RA_CNT:  reg_rdata = {cnt[HI_IDX], cnt[LO_IDX]};
         RA_STAT: reg_rdata = RD_W'(flags);
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/pmu_dual_counter_chk.sv
module pmu_dual_counter_chk #(
   parameter int CNT_W     = 32,
   parameter int SEL_W     = 12,
   parameter int PARK_CODE = 'h220
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cnt_acc,
   input logic [1:0]         reg_half,
   input logic [2*CNT_W-1:0] reg_wdata,
   input logic               ctrl_wr,
   input logic               ctx_ok,
   input logic [SEL_W-1:0]   sel_lo,
   input logic [CNT_W-1:0]   cnt_lo,
   input logic [1:0]         wrap,
   input logic [1:0]         flags,
   input logic               irq
);

   logic wr_lo;
   assign wr_lo = cnt_acc && reg_half[0];

   // R4
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_lo |=> (cnt_lo == $past(cnt_lo)) || (cnt_lo == $past(cnt_lo) + CNT_W'(1)));

   // R5
   idle_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctx_ok && !wr_lo) |=> $stable(cnt_lo));

   // R6
   parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_lo == SEL_W'(PARK_CODE) && !wr_lo) |=> $stable(cnt_lo));

   // R7
   wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> cnt_lo == $past(reg_wdata[CNT_W-1:0]));

   // R8
   wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[0] |=> flags[0]);

   // R10
   ctrl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wrap == 2'b00) |=> flags == 2'b00);

   // R9
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(|wrap) || $past(ctrl_wr)));

endmodule

bind pmu_dual_counter pmu_dual_counter_chk #(
   .CNT_W     (CNT_W),
   .SEL_W     (SEL_W),
   .PARK_CODE (PARK_CODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_acc   (cnt_acc),
   .reg_half  (reg_half),
   .reg_wdata (reg_wdata),
   .ctrl_wr   (ctrl_wr),
   .ctx_ok    (ctx_ok),
   .sel_lo    (sel_vec[0]),
   .cnt_lo    (cnt[0]),
   .wrap      (wrap),
   .flags     (flags),
   .irq       (irq)
);

// File: tb/pmu_dual_counter_tb.sv
`timescale 1ns/1ps
module pmu_dual_counter_tb;

   localparam int NEV = 16;
   localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_STAT = 2'd2;
   localparam int IRQ_SLOT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [63:0] reg_wdata = '0;
   logic [1:0]  reg_half = 2'b00;
   logic [63:0] reg_rdata;
   logic [NEV-1:0] evt_strobe = '0;
   logic [1:0]  priv_ctx = 2'd0;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      int          slot;
      logic [63:0] exp;
      string       tag;
   } item_t;
   item_t q[$];

   always #10 clk = ~clk;

   pmu_dual_counter u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_half(reg_half), .reg_rdata(reg_rdata),
      .evt_strobe(evt_strobe), .priv_ctx(priv_ctx), .irq(irq)
   );

   // monitor: pops expected items and compares with what the design shows
   initial begin
      forever begin
         wait (q.size() != 0);
         begin
            item_t it;
            logic [63:0] act;
            it  = q.pop_front();
            act = (it.slot == IRQ_SLOT) ? 64'(irq) : reg_rdata;
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   function automatic logic [63:0] mk_ctrl(input logic [11:0] hi, input logic [11:0] lo,
                                           input logic [2:0] en, input logic [1:0] ie);
      return 64'({hi, 1'b0, lo, ie, en, 1'b0});
   endfunction

   task automatic expect_slot(input int slot, input logic [63:0] exp, input string tag);
      if (slot != IRQ_SLOT) reg_addr = slot[1:0];
      #2;
      q.push_back('{slot, exp, tag});
      #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [63:0] d, input logic [1:0] h);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_half = h;
      @(negedge clk);
      reg_wr = 1'b0; reg_half = 2'b00;
   endtask

   task automatic pulse(input logic [NEV-1:0] e, input int n);
      @(negedge clk);
      evt_strobe = e;
      repeat (n) @(negedge clk);
      evt_strobe = '0;
   endtask

   initial begin
      logic [63:0] c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      expect_slot(A_CTRL, 64'd0, "R1 ctrl");
      expect_slot(A_CNT,  64'd0, "R1 counters");
      expect_slot(A_STAT, 64'd0, "R1 status");
      expect_slot(IRQ_SLOT, 64'd0, "R1 irq");

      // R3 layout readback
      c = mk_ctrl(12'd5, 12'd3, 3'b001, 2'b11);
      wr(A_CTRL, c, 2'b00);
      expect_slot(A_CTRL, 64'h0000_0000_0028_00F2, "R3 ctrl readback");

      // R4 user-context counting
      c = mk_ctrl(12'd5, 12'd3, 3'b001, 2'b00);
      wr(A_CTRL, c, 2'b00);
      priv_ctx = 2'd0;
      pulse(16'h0028, 2);
      pulse(16'h0008, 3);
      expect_slot(A_CNT, {32'd2, 32'd5}, "R4 user count");
      priv_ctx = 2'd1;
      pulse(16'hFFFF, 4);
      expect_slot(A_CNT, {32'd2, 32'd5}, "R4 supervisor not enabled");
      priv_ctx = 2'd3;
      pulse(16'hFFFF, 4);
      expect_slot(A_CNT, {32'd2, 32'd5}, "R4 context 3 never counts");

      // R5 all context bits clear
      wr(A_CTRL, mk_ctrl(12'd5, 12'd3, 3'b000, 2'b00), 2'b00);
      priv_ctx = 2'd2;
      pulse(16'hFFFF, 4);
      expect_slot(A_CNT, {32'd2, 32'd5}, "R5 all contexts off");
      wr(A_CTRL, mk_ctrl(12'd5, 12'd3, 3'b100, 2'b00), 2'b00);
      pulse(16'h0028, 3);
      expect_slot(A_CNT, {32'd5, 32'd8}, "R4 hypervisor count");

      // R2 half writes
      wr(A_CNT, {32'hAAAA_0000, 32'h1234_5678}, 2'b01);
      expect_slot(A_CNT, {32'd5, 32'h1234_5678}, "R2 lower half write");
      wr(A_CNT, {32'hDEAD_BEEF, 32'h0}, 2'b10);
      expect_slot(A_CNT, {32'hDEAD_BEEF, 32'h1234_5678}, "R2 upper half write");

      // R6 park code and out-of-range code
      priv_ctx = 2'd0;
      wr(A_CTRL, mk_ctrl(12'd5, 12'h220, 3'b001, 2'b00), 2'b00);
      pulse(16'hFFFF, 3);
      expect_slot(A_CNT, {32'hDEAD_BEF2, 32'h1234_5678}, "R6 lower parked, upper runs");
      wr(A_CTRL, mk_ctrl(12'h220, 12'h100, 3'b001, 2'b00), 2'b00);
      pulse(16'hFFFF, 3);
      expect_slot(A_CNT, {32'hDEAD_BEF2, 32'h1234_5678}, "R6 both silent");

      // R7 load beats increment, neighbour still counts
      wr(A_CTRL, mk_ctrl(12'd5, 12'd3, 3'b001, 2'b00), 2'b00);
      @(negedge clk);
      evt_strobe = 16'h0028;
      reg_wr = 1'b1; reg_addr = A_CNT; reg_wdata = {32'h0, 32'd100}; reg_half = 2'b01;
      @(negedge clk);
      reg_wr = 1'b0; reg_half = 2'b00; evt_strobe = '0;
      expect_slot(A_CNT, {32'hDEAD_BEF3, 32'd100}, "R7 load priority");

      // R8 loads do not set flags; rollover does
      wr(A_CNT, {32'h0, 32'hFFFF_FFFF}, 2'b01);
      wr(A_CNT, {32'h0, 32'h0}, 2'b01);
      expect_slot(A_STAT, 64'd0, "R8 load through port no flag");
      wr(A_CNT, {32'h0, 32'hFFFF_FFFE}, 2'b01);
      pulse(16'h0008, 2);
      expect_slot(A_CNT, {32'hDEAD_BEF3, 32'h0}, "R8 lower wrapped");
      expect_slot(A_STAT, 64'd1, "R8 lower flag");
      expect_slot(IRQ_SLOT, 64'd0, "R9 flag without enable keeps irq low");
      repeat (3) @(negedge clk);
      expect_slot(A_STAT, 64'd1, "R8 flag sticky");

      // R9/R10 interrupt and clearing
      c = mk_ctrl(12'd5, 12'd3, 3'b001, 2'b01);
      wr(A_CTRL, c, 2'b00);
      expect_slot(A_STAT, 64'd0, "R10 ctrl write clears");
      expect_slot(IRQ_SLOT, 64'd0, "R10 irq low after clear");
      wr(A_CNT, {32'h0, 32'hFFFF_FFFF}, 2'b01);
      pulse(16'h0008, 1);
      expect_slot(A_STAT, 64'd1, "R8 wrap sets flag");
      expect_slot(IRQ_SLOT, 64'd1, "R9 irq raised");
      wr(A_CTRL, c, 2'b00);
      expect_slot(A_STAT, 64'd0, "R10 same-value write clears");
      expect_slot(IRQ_SLOT, 64'd0, "R10 irq dropped");

      // R10 rollover coinciding with control write
      wr(A_CNT, {32'h0, 32'hFFFF_FFFF}, 2'b01);
      @(negedge clk);
      evt_strobe = 16'h0008;
      reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = c;
      @(negedge clk);
      reg_wr = 1'b0; evt_strobe = '0;
      expect_slot(A_STAT, 64'd1, "R10 coincident wrap survives");
      expect_slot(IRQ_SLOT, 64'd1, "R10 coincident irq");

      // R8/R9 upper counter
      wr(A_CTRL, mk_ctrl(12'd5, 12'd3, 3'b001, 2'b10), 2'b00);
      wr(A_CNT, {32'hFFFF_FFFF, 32'h0}, 2'b10);
      pulse(16'h0020, 1);
      expect_slot(A_CNT, {32'h0, 32'h0}, "R8 upper wrapped");
      expect_slot(A_STAT, 64'd2, "R8 upper flag");
      expect_slot(IRQ_SLOT, 64'd1, "R9 upper irq");

      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule